// File: doc/BRIEF.md
# Scaled Raster Interrupt Generator

This block raises a raster-line interrupt for a high-resolution video timing chain that stands in for a legacy display with far fewer lines. The timing generator supplies a strobe at the start of each physical line and a frame-start marker. From these the block keeps a logical raster counter that advances once every few physical lines. A logical line takes more physical lines inside the visible display area than in the border regions, so the logical frame fills the physical frame exactly.

The physical frame has only one blanked line before the picture, while the emulated raster has several. Logical line 0 therefore starts a fixed number of physical lines before the frame-start marker, in the flyback of the previous frame. On frame start the counter is loaded with the logical line and physical phase that this offset implies, which keeps it locked to the frame.

The CPU sets a 9-bit compare value, reads the current logical line, and sets an interrupt enable through a small register window. A status bit records a match. Writing a one to the status bit clears it, so writing back the value just read clears every flagged event. The interrupt output passes through one register stage after the enable gate, which gives the routing room to reach the CPU.

Top module: `scaled_raster_irq`

## Requirements
- R1: The logical line counter runs from 0 to LOG_LINES-1 and then wraps to 0. A read at address 0 returns its low 8 bits. A read at address 1 returns its bit 8 in bit 7, with bits 6..0 reading 0.
- R2: A logical line lasts SPAN_DISP physical line strobes when its number lies between DISP_FIRST and DISP_LAST, both inclusive. Any other logical line lasts SPAN_BORDER strobes.
- R3: A line strobe that comes with frame_start loads the counter with the position LEAD_LINES physical lines after the start of logical line 0. That position is line LEAD_LINES/SPAN_BORDER at phase LEAD_LINES%SPAN_BORDER. A frame_start without a strobe has no effect.
- R4: The compare value is 9 bits. A write to address 0 sets bits 7..0 from the write data. A write to address 1 sets bit 8 from write-data bit 7. The compare value cannot be read back.
- R5: The status bit (bit 0 of address 2) is set one clock after the strobe that starts a logical line equal to the compare value. It is set only on the first physical line of that logical line.
- R6: A write to address 2 with bit 0 set clears the status bit, and bit 0 clear leaves it unchanged. If a new match and a clear fall in the same clock, the match wins.
- R7: Bit 0 at address 3 is the enable. A read of address 2 returns status AND enable in bit 7. irq_o goes high one clock after status and enable are both high, and it drops one clock after either falls.
- R8: After reset the counter, compare value, status, enable and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_strobe | input | 1 | One-clock pulse at the start of each physical line |
| frame_start | input | 1 | High together with the strobe of the first physical line of a frame |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 line/compare low, 1 line/compare bit 8, 2 status, 3 enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The bench builds the block with a 12-line logical frame. Lines 3 to 8 are display lines of 5 strobes each, the rest are border lines of 3 strobes, and the lead-in is 4 physical lines. That gives a 48-line physical frame, so a single run covers many wraps, frame loads that land in mid-line, and matches on border lines, display lines and the last line. Compare values with bit 8 set cannot be reached at this size, which checks that bit 8 takes part in the match. A free-running phase before the first frame start checks that loading re-phases a counter that was already running.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned SRQ_CMP_W = 9;

  typedef enum logic [1:0] {
    SRQ_LINE_LO = 2'd0,
    SRQ_LINE_HI = 2'd1,
    SRQ_STATUS  = 2'd2,
    SRQ_ENABLE  = 2'd3
  } srq_addr_e;
endpackage

// File: rtl/srq_line_counter.sv
module srq_line_counter #(
  parameter int unsigned LOG_LINES   = 312,
  parameter int unsigned SPAN_BORDER = 3,
  parameter int unsigned SPAN_DISP   = 5,
  parameter int unsigned DISP_FIRST  = 78,
  parameter int unsigned DISP_LAST   = 233,
  parameter int unsigned LEAD_LINES  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_strobe,
  input  logic                         frame_start,
  output logic [$clog2(LOG_LINES)-1:0] line_o,
  output logic                         first_line_o
);
  localparam int unsigned LINE_W    = $clog2(LOG_LINES);
  localparam int unsigned MAX_SPAN  = (SPAN_DISP > SPAN_BORDER) ? SPAN_DISP : SPAN_BORDER;
  localparam int unsigned SUB_W     = $clog2(MAX_SPAN);
  localparam int unsigned SYNC_LINE = LEAD_LINES / SPAN_BORDER;
  localparam int unsigned SYNC_SUB  = LEAD_LINES % SPAN_BORDER;

  logic [LINE_W-1:0] line_q, line_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic              strb_q;
  logic              in_disp;
  logic [SUB_W-1:0]  last_sub;

  assign in_disp  = (line_q >= LINE_W'(DISP_FIRST)) && (line_q <= LINE_W'(DISP_LAST));
  assign last_sub = in_disp ? SUB_W'(SPAN_DISP - 1) : SUB_W'(SPAN_BORDER - 1);

  always_comb begin
    line_d = line_q;
    sub_d  = sub_q;
    if (line_strobe) begin
      if (frame_start) begin
        line_d = LINE_W'(SYNC_LINE);
        sub_d  = SUB_W'(SYNC_SUB);
      end else if (sub_q == last_sub) begin
        sub_d  = '0;
        line_d = (line_q == LINE_W'(LOG_LINES - 1)) ? '0 : line_q + 1'b1;
      end else begin
        sub_d  = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      sub_q  <= '0;
      strb_q <= 1'b0;
    end else begin
      strb_q <= line_strobe;
      if (line_strobe) begin
        line_q <= line_d;
        sub_q  <= sub_d;
      end
    end
  end

  assign line_o       = line_q;
  assign first_line_o = strb_q && (sub_q == '0);
endmodule

// File: rtl/srq_event_regs.sv
module srq_event_regs
  import srq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  input  logic [SRQ_CMP_W-1:0] line_i,
  input  logic                 first_line_i,
  output logic [7:0]           reg_rdata,
  output logic [SRQ_CMP_W-1:0] cmp_o,
  output logic                 pend_o,
  output logic                 en_o,
  output logic                 irq_o
);
  srq_addr_e            addr;
  logic [SRQ_CMP_W-1:0] cmp_q, cmp_d;
  logic                 pend_q, pend_d;
  logic                 en_q, en_d;
  logic                 irq_q, irq_d;
  logic                 hit, clr;

  assign addr = srq_addr_e'(reg_addr);
  assign hit  = first_line_i && (line_i == cmp_q);
  assign clr  = reg_wr && (addr == SRQ_STATUS) && reg_wdata[0];

  always_comb begin
    cmp_d  = cmp_q;
    en_d   = en_q;
    pend_d = hit || (pend_q && !clr);
    irq_d  = pend_q && en_q;
    if (reg_wr && addr == SRQ_LINE_LO) cmp_d[7:0] = reg_wdata;
    if (reg_wr && addr == SRQ_LINE_HI) cmp_d[8]   = reg_wdata[7];
    if (reg_wr && addr == SRQ_ENABLE)  en_d       = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_wr) begin
        cmp_q <= cmp_d;
        en_q  <= en_d;
      end
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    unique case (addr)
      SRQ_LINE_LO: reg_rdata = line_i[7:0];
      SRQ_LINE_HI: reg_rdata = {line_i[8], 7'b0};
      SRQ_STATUS:  reg_rdata = {pend_q && en_q, 6'b0, pend_q};
      default:     reg_rdata = {7'b0, en_q};
    endcase
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/scaled_raster_irq.sv
module scaled_raster_irq
  import srq_pkg::*;
#(
  parameter int unsigned LOG_LINES   = 312,
  parameter int unsigned SPAN_BORDER = 3,
  parameter int unsigned SPAN_DISP   = 5,
  parameter int unsigned DISP_FIRST  = 78,
  parameter int unsigned DISP_LAST   = 233,
  parameter int unsigned LEAD_LINES  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_strobe,
  input  logic       frame_start,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o
);
  localparam int unsigned LINE_W = $clog2(LOG_LINES);

  logic                 rst_meta, rst_sync_n;
  logic [LINE_W-1:0]    line_cnt;
  logic [SRQ_CMP_W-1:0] line_ext;
  logic [SRQ_CMP_W-1:0] cmp_val;
  logic                 first_line;
  logic                 raster_pend;
  logic                 irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  srq_line_counter #(
    .LOG_LINES  (LOG_LINES),
    .SPAN_BORDER(SPAN_BORDER),
    .SPAN_DISP  (SPAN_DISP),
    .DISP_FIRST (DISP_FIRST),
    .DISP_LAST  (DISP_LAST),
    .LEAD_LINES (LEAD_LINES)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .line_strobe (line_strobe),
    .frame_start (frame_start),
    .line_o      (line_cnt),
    .first_line_o(first_line)
  );

  assign line_ext = SRQ_CMP_W'(line_cnt);

  srq_event_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .line_i      (line_ext),
    .first_line_i(first_line),
    .reg_rdata   (reg_rdata),
    .cmp_o       (cmp_val),
    .pend_o      (raster_pend),
    .en_o        (irq_en),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int unsigned LOG_LINES   = 312,
  parameter int unsigned SPAN_BORDER = 3,
  parameter int unsigned LEAD_LINES  = 6
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       line_strobe,
  input logic       frame_start,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [8:0] line_ext,
  input logic [8:0] cmp_val,
  input logic       first_line,
  input logic       raster_pend,
  input logic       irq_en,
  input logic       irq_o
);
  localparam int unsigned SYNC_LINE = LEAD_LINES / SPAN_BORDER;

  a_r1_line_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_ext < 9'(LOG_LINES));

  a_r3_frame_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (line_strobe && frame_start) |=> (line_ext == 9'(SYNC_LINE)));

  a_r5_set_on_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(raster_pend) |-> $past(first_line && (line_ext == cmp_val)));

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[0] && !(first_line && line_ext == cmp_val))
    |=> !raster_pend);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> $past(raster_pend && irq_en));
endmodule

bind scaled_raster_irq srq_checker #(
  .LOG_LINES  (LOG_LINES),
  .SPAN_BORDER(SPAN_BORDER),
  .LEAD_LINES (LEAD_LINES)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .line_strobe(line_strobe),
  .frame_start(frame_start),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .line_ext   (line_ext),
  .cmp_val    (cmp_val),
  .first_line (first_line),
  .raster_pend(raster_pend),
  .irq_en     (irq_en),
  .irq_o      (irq_o)
);

// File: tb/scaled_raster_irq_tb.sv
module scaled_raster_irq_tb;
  localparam int LOG   = 12;
  localparam int SB    = 3;
  localparam int SD    = 5;
  localparam int DF    = 3;
  localparam int DL    = 8;
  localparam int LEAD  = 4;
  localparam int PHYS  = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_strobe = 1'b0;
  logic       frame_start = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  always #2.5 clk = ~clk;

  scaled_raster_irq #(
    .LOG_LINES(LOG), .SPAN_BORDER(SB), .SPAN_DISP(SD),
    .DISP_FIRST(DF), .DISP_LAST(DL), .LEAD_LINES(LEAD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .frame_start(frame_start),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  int m_line = 0, m_sub = 0, m_sd = 0, m_pend = 0, m_en = 0, m_cmp = 0, m_irq = 0;
  int m_s1 = 0, m_s2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      m_line = 0; m_sub = 0; m_sd = 0; m_pend = 0; m_en = 0; m_cmp = 0; m_irq = 0;
    end else begin
      bit in_rst;
      in_rst = (m_s2 == 0);
      m_s2 = m_s1; m_s1 = 1;
      if (!in_rst) begin
        int span, hit, clr;
        span = (m_line >= DF && m_line <= DL) ? SD : SB;
        hit = (m_sd != 0 && m_sub == 0 && m_line == m_cmp);
        clr = (reg_wr && reg_addr == 2 && reg_wdata[0]);
        m_irq = (m_pend != 0 && m_en != 0);
        m_pend = (hit != 0 || (m_pend != 0 && clr == 0));
        if (reg_wr && reg_addr == 0) m_cmp = (m_cmp & 256) | int'(reg_wdata);
        if (reg_wr && reg_addr == 1) m_cmp = (m_cmp & 255) | (reg_wdata[7] ? 256 : 0);
        if (reg_wr && reg_addr == 3) m_en = reg_wdata[0];
        if (line_strobe) begin
          if (frame_start) begin
            m_line = LEAD / SB; m_sub = LEAD % SB;
          end else if (m_sub == span - 1) begin
            m_sub = 0; m_line = (m_line + 1) % LOG;
          end else m_sub = m_sub + 1;
        end
        m_sd = line_strobe;
      end
    end
  end

  function automatic logic [7:0] exp_rd(input int a);
    case (a)
      0: return 8'(m_line & 255);
      1: return (m_line >= 256) ? 8'h80 : 8'h00;
      2: return {(m_pend != 0 && m_en != 0), 6'b0, (m_pend != 0)};
      default: return {7'b0, (m_en != 0)};
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus state
  int  gcnt = 0;
  int  phys = 0;
  bit  frames_on = 0;
  bit  nxt_wr = 0;
  logic [1:0] nxt_addr = 0;
  logic [7:0] nxt_data = 0;
  bit  hold = 0;
  logic [1:0] hold_addr = 0;

  task automatic tick();
    @(negedge clk);
    check("R7 irq_o", irq_o, m_irq);
    case (reg_addr)
      2'd0, 2'd1: check("R1 line read", reg_rdata, exp_rd(reg_addr));
      2'd2:       check("R5/R6 status read", reg_rdata, exp_rd(2));
      default:    check("R7 enable read", reg_rdata, exp_rd(3));
    endcase
    gcnt++;
    line_strobe = (gcnt % 3 == 0);
    frame_start = 1'b0;
    if (line_strobe) begin
      phys = (phys + 1) % PHYS;
      frame_start = frames_on && (phys == 0);
    end
    reg_wr    = nxt_wr;
    reg_wdata = nxt_data;
    reg_addr  = nxt_wr ? nxt_addr : (hold ? hold_addr : 2'(gcnt % 4));
    nxt_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    nxt_wr = 1; nxt_addr = a; nxt_data = d;
    tick();
  endtask

  task automatic run(input int n, input bit serve, inout int rises);
    bit prev;
    prev = irq_o;
    for (int i = 0; i < n; i++) begin
      if (serve && irq_o && !nxt_wr) begin nxt_wr = 1; nxt_addr = 2; nxt_data = 8'h01; end
      tick();
      if (irq_o && !prev) rises++;
      prev = irq_o;
    end
  endtask

  initial begin
    int rises;
    for (int i = 0; i < 4; i++) tick();
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    // R8: reset values through the register window
    hold = 1;
    for (int a = 0; a < 4; a++) begin
      hold_addr = 2'(a); tick(); tick();
      check("R8 reset read", reg_rdata, 0);
    end
    check("R8 reset irq", irq_o, 0);
    hold = 0;
    rises = 0;
    // R1/R2: free-running count before any frame start
    run(100, 0, rises);
    // R3: frame starts re-phase the counter
    frames_on = 1;
    run(300, 0, rises);
    // R4/R5/R7: match on a display line, serviced by write-one-to-clear (R6)
    wr(2'd0, 8'd5); wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    rises = 0;
    run(300, 1, rises);
    check("R5 irq seen on display-line match", rises > 0, 1);
    // R4: bit 8 set makes the compare unreachable
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h80);
    rises = 0;
    run(300, 1, rises);
    check("R4 no match with bit 8 set", rises, 0);
    // R2: border and wrap lines
    wr(2'd1, 8'h00); wr(2'd0, 8'd11);
    rises = 0;
    run(300, 1, rises);
    check("R2 irq on last line", rises > 0, 1);
    wr(2'd0, 8'd1);
    run(300, 1, rises);
    wr(2'd0, 8'd0);
    run(300, 1, rises);
    // R7: disabled, status still sets, irq stays low
    wr(2'd3, 8'h00);
    rises = 0;
    run(300, 0, rises);
    check("R7 no irq when disabled", rises, 0);
    hold = 1; hold_addr = 2'd2; tick(); tick();
    check("R5 status pending while disabled", reg_rdata[0], 1);
    // R6: writing zero does not clear; writing one does
    wr(2'd2, 8'hFE); hold_addr = 2'd2; tick();
    check("R6 zero write keeps status", reg_rdata[0], exp_rd(2) & 1);
    wr(2'd2, 8'h81); tick();
    check("R6 write one clears", reg_rdata[0], exp_rd(2) & 1);
    // R7: enabling with pending status raises irq after one clock
    hold = 0;
    run(200, 0, rises);
    wr(2'd3, 8'h01);
    run(200, 1, rises);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule